// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block drives the pad-level strobes of a raw NAND flash interface for one bus cycle at a time. A cycle can be a command latch, an address latch, a data write or a data read. The requester presents a cycle type, a byte and two packed timing words. The block then sequences the latch enables, the write-enable or read-enable strobe, the output enable and the data bus. It captures the read byte at a programmable access point and reports completion with a single-clock pulse.

All timings are whole clock ticks that software has already converted from nanoseconds. The write strobe low time comes from a cycle-time value minus a high-portion value, not from a fixed constant. A count of zero still gives one tick. Both timing words are captured when a cycle is accepted, so software may reprogram them while a cycle runs. The open-drain ready/busy line from the flash is brought into the clock domain through a flop synchronizer and presented as a status output.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, pad_we_n and pad_re_n are 1, and pad_cle, pad_ale, pad_doe, done and busy are 0.
- R2: The write word holds four 8-bit tick fields: [31:24] setup, [23:16] write extension, [15:8] write cycle, [7:0] write high portion. The read word holds: [31:24] access, [23:16] read-enable high hold, [15:8] read-enable low, [7:0] bus release. Every cycle begins with a setup phase of the setup count, with both strobes high.
- R3: A field value of zero produces a phase of one tick.
- R4: In a write-type cycle, pad_we_n is low for (write cycle − write high) ticks, or for 1 tick when write cycle ≤ write high. It is then high for the write high count.
- R5: req_kind encodes 0 = command, 1 = address, 2 = data write, 3 = data read. A command cycle holds pad_cle high, and an address cycle holds pad_ale high, through setup, strobe low and strobe high. Data cycles keep both low.
- R6: In cycles of kind 0, 1 and 2, pad_doe is high with pad_dout equal to req_data through setup, strobe low and strobe high. pad_doe is low at all other times.
- R7: After the write-enable high phase, the block waits the write extension count before it pulses done. A write-type cycle therefore spans setup + low + high + extension ticks from acceptance to done.
- R8: In a read cycle, pad_re_n is low for the read-enable low count and then high for the hold count. The release count follows before done. pad_doe stays low throughout.
- R9: rd_data takes pad_din at the clock edge that ends tick N after pad_re_n falls, where N is the access count. If N is past the end of the hold phase, the sample is taken at the last edge of the hold phase.
- R10: busy is high from the cycle after acceptance until done. done is a one-clock pulse. Requests presented while busy are ignored.
- R11: The timing words, kind and byte are captured when a request is accepted. Changing them later does not affect the running cycle.
- R12: dev_ready follows rb_n after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request; accepted only when idle |
| req_kind | input | 2 | Cycle type (0 cmd, 1 addr, 2 write, 3 read) |
| req_data | input | 8 | Byte to drive for kinds 0 to 2 |
| cfg_wr_timing | input | 32 | Packed setup/extension/cycle/high tick counts |
| cfg_rd_timing | input | 32 | Packed access/hold/low/release tick counts |
| rb_n | input | 1 | Ready/busy line from the flash, 1 = ready |
| pad_din | input | 8 | Data bus input from the pads |
| pad_cle | output | 1 | Command latch enable |
| pad_ale | output | 1 | Address latch enable |
| pad_we_n | output | 1 | Write enable, active low |
| pad_re_n | output | 1 | Read enable, active low |
| pad_dout | output | 8 | Data bus output |
| pad_doe | output | 1 | Data bus output enable |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Cycle in progress |
| dev_ready | output | 1 | Synchronized ready/busy status |

## Verification
A phase counter or phase register that goes wrong shows up directly in the number of clocks a strobe spends low or high. It also shows up in the distance from acceptance to done. Both errors appear within the same cycle, so every cycle is measured edge by edge against tick counts derived from the packed words. An access-point error shows only in rd_data, so the pad input takes a new value every clock and the captured byte identifies the exact sampling edge. A lost snapshot or a missed refusal changes the measured timing of the cycle that was running when the inputs changed.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } bus_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_WE_LO = 3'd2,
    PH_WE_HI = 3'd3,
    PH_W_EXT = 3'd4,
    PH_RE_LO = 3'd5,
    PH_RE_HI = 3'd6,
    PH_R_REL = 3'd7
  } bus_phase_e;

endpackage

// File: rtl/nand_strobe_decode.sv
// Splits the two packed timing words into per-phase tick counts, each >= 1.
module nand_strobe_decode #(
  parameter int unsigned TICK_W = 8
) (
  input  logic [4*TICK_W-1:0] wr_word,
  input  logic [4*TICK_W-1:0] rd_word,
  output logic [TICK_W-1:0]   t_setup,
  output logic [TICK_W-1:0]   t_we_lo,
  output logic [TICK_W-1:0]   t_we_hi,
  output logic [TICK_W-1:0]   t_w_ext,
  output logic [TICK_W-1:0]   t_access,
  output logic [TICK_W-1:0]   t_re_lo,
  output logic [TICK_W-1:0]   t_re_hi,
  output logic [TICK_W-1:0]   t_r_rel
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  function automatic logic [TICK_W-1:0] min_one(input logic [TICK_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [TICK_W-1:0] wf [4];
  logic [TICK_W-1:0] rf [4];

  for (genvar i = 0; i < 4; i++) begin : g_field
    assign wf[i] = wr_word[i*TICK_W +: TICK_W];
    assign rf[i] = rd_word[i*TICK_W +: TICK_W];
  end

  // wf[3] setup, wf[2] extension, wf[1] cycle, wf[0] high portion
  assign t_setup  = min_one(wf[3]);
  assign t_w_ext  = min_one(wf[2]);
  assign t_we_hi  = min_one(wf[0]);
  assign t_we_lo  = (wf[1] > wf[0]) ? (wf[1] - wf[0]) : ONE;
  // rf[3] access, rf[2] high hold, rf[1] low, rf[0] release
  assign t_access = min_one(rf[3]);
  assign t_re_hi  = min_one(rf[2]);
  assign t_re_lo  = min_one(rf[1]);
  assign t_r_rel  = min_one(rf[0]);
endmodule

// File: rtl/nand_strobe_ticker.sv
// Loadable down counter that times one phase.
module nand_strobe_ticker #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_strobe_sync.sv
// Flop chain that brings an asynchronous level into the clock domain.
module nand_strobe_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int unsigned TICK_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [4*TICK_W-1:0] cfg_wr_timing,
  input  logic [4*TICK_W-1:0] cfg_rd_timing,
  input  logic                rb_n,
  input  logic [DATA_W-1:0]   pad_din,
  output logic                pad_cle,
  output logic                pad_ale,
  output logic                pad_we_n,
  output logic                pad_re_n,
  output logic [DATA_W-1:0]   pad_dout,
  output logic                pad_doe,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic                busy,
  output logic                dev_ready
);
  localparam int unsigned WORD_W = 4 * TICK_W;
  localparam int unsigned ELAP_W = TICK_W + 1;
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  bus_phase_e        phase_q, phase_d;
  bus_kind_e         kind_q, kind_now;
  logic [DATA_W-1:0] data_q, data_now;
  logic [WORD_W-1:0] wr_word_q, rd_word_q, wr_sel, rd_sel;
  logic              accept, idle;

  logic [TICK_W-1:0] t_setup, t_we_lo, t_we_hi, t_w_ext;
  logic [TICK_W-1:0] t_access, t_re_lo, t_re_hi, t_r_rel;

  logic              tick_load, tick_zero, finish;
  logic [TICK_W-1:0] tick_val;

  // ---------------- request snapshot ----------------
  assign idle   = (phase_q == PH_IDLE);
  assign accept = idle && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= KIND_CMD;
      data_q    <= '0;
      wr_word_q <= '0;
      rd_word_q <= '0;
    end else if (accept) begin
      kind_q    <= bus_kind_e'(req_kind);
      data_q    <= req_data;
      wr_word_q <= cfg_wr_timing;
      rd_word_q <= cfg_rd_timing;
    end
  end

  assign wr_sel   = idle ? cfg_wr_timing : wr_word_q;
  assign rd_sel   = idle ? cfg_rd_timing : rd_word_q;
  assign kind_now = idle ? bus_kind_e'(req_kind) : kind_q;
  assign data_now = idle ? req_data : data_q;

  nand_strobe_decode #(.TICK_W(TICK_W)) u_decode (
    .wr_word  (wr_sel),
    .rd_word  (rd_sel),
    .t_setup  (t_setup),
    .t_we_lo  (t_we_lo),
    .t_we_hi  (t_we_hi),
    .t_w_ext  (t_w_ext),
    .t_access (t_access),
    .t_re_lo  (t_re_lo),
    .t_re_hi  (t_re_hi),
    .t_r_rel  (t_r_rel)
  );

  nand_strobe_ticker #(.W(TICK_W)) u_ticker (
    .clk      (clk),
    .rst      (rst),
    .load     (tick_load),
    .load_val (tick_val),
    .expired  (tick_zero)
  );

  // ---------------- phase sequencer ----------------
  always_comb begin
    phase_d   = phase_q;
    tick_load = 1'b0;
    tick_val  = '0;
    finish    = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        phase_d   = PH_SETUP;
        tick_load = 1'b1;
        tick_val  = t_setup - ONE;
      end
      PH_SETUP: if (tick_zero) begin
        tick_load = 1'b1;
        if (kind_q == KIND_RDATA) begin
          phase_d  = PH_RE_LO;
          tick_val = t_re_lo - ONE;
        end else begin
          phase_d  = PH_WE_LO;
          tick_val = t_we_lo - ONE;
        end
      end
      PH_WE_LO: if (tick_zero) begin
        phase_d   = PH_WE_HI;
        tick_load = 1'b1;
        tick_val  = t_we_hi - ONE;
      end
      PH_WE_HI: if (tick_zero) begin
        phase_d   = PH_W_EXT;
        tick_load = 1'b1;
        tick_val  = t_w_ext - ONE;
      end
      PH_RE_LO: if (tick_zero) begin
        phase_d   = PH_RE_HI;
        tick_load = 1'b1;
        tick_val  = t_re_hi - ONE;
      end
      PH_RE_HI: if (tick_zero) begin
        phase_d   = PH_R_REL;
        tick_load = 1'b1;
        tick_val  = t_r_rel - ONE;
      end
      PH_W_EXT, PH_R_REL: if (tick_zero) begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  // ---------------- registered pad controls ----------------
  logic drive_span;
  assign drive_span = (kind_now != KIND_RDATA) &&
                      ((phase_d == PH_SETUP) || (phase_d == PH_WE_LO) ||
                       (phase_d == PH_WE_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_cle  <= 1'b0;
      pad_ale  <= 1'b0;
      pad_we_n <= 1'b1;
      pad_re_n <= 1'b1;
      pad_doe  <= 1'b0;
      pad_dout <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      pad_cle  <= drive_span && (kind_now == KIND_CMD);
      pad_ale  <= drive_span && (kind_now == KIND_ADDR);
      pad_we_n <= (phase_d != PH_WE_LO);
      pad_re_n <= (phase_d != PH_RE_LO);
      pad_doe  <= drive_span;
      pad_dout <= drive_span ? data_now : '0;
      done     <= finish;
      busy     <= (phase_d != PH_IDLE);
    end
  end

  // ---------------- read capture point ----------------
  logic [ELAP_W-1:0] elapsed_q, elapsed_inc;
  logic              taken_q, in_read_strobe, cap_now;

  assign in_read_strobe = (phase_q == PH_RE_LO) || (phase_q == PH_RE_HI);
  assign elapsed_inc    = elapsed_q + ELAP_W'(1);
  assign cap_now        = in_read_strobe && !taken_q &&
                          ((elapsed_inc == ELAP_W'(t_access)) ||
                           ((phase_q == PH_RE_HI) && tick_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
      taken_q   <= 1'b0;
      rd_data   <= '0;
    end else if ((phase_q != PH_RE_LO) && (phase_d == PH_RE_LO)) begin
      elapsed_q <= '0;
      taken_q   <= 1'b0;
    end else if (in_read_strobe) begin
      elapsed_q <= elapsed_inc;
      if (cap_now) begin
        rd_data <= pad_din;
        taken_q <= 1'b1;
      end
    end
  end

  // ---------------- ready/busy synchronizer ----------------
  nand_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rb_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rb_n),
    .dout (dev_ready)
  );
endmodule

// File: rtl/nand_strobe_gen_chk.sv
module nand_strobe_gen_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pad_cle,
  input logic              pad_ale,
  input logic              pad_we_n,
  input logic              pad_re_n,
  input logic              pad_doe,
  input logic [DATA_W-1:0] pad_dout,
  input logic              done,
  input logic              busy,
  input logic              rb_n,
  input logic              dev_ready
);
  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!pad_we_n && !pad_re_n)); // R8
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pad_cle && pad_ale)); // R5
  AST_LATCH_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (pad_cle || pad_ale) |-> pad_doe); // R5
  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !pad_we_n |-> pad_doe); // R6
  AST_RE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !pad_re_n |-> !pad_doe); // R8
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (pad_doe && $past(pad_doe)) |-> $stable(pad_dout)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (dev_ready == $past(rb_n, 2))); // R12
endmodule

bind nand_strobe_gen nand_strobe_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pad_cle   (pad_cle),
  .pad_ale   (pad_ale),
  .pad_we_n  (pad_we_n),
  .pad_re_n  (pad_re_n),
  .pad_doe   (pad_doe),
  .pad_dout  (pad_dout),
  .done      (done),
  .busy      (busy),
  .rb_n      (rb_n),
  .dev_ready (dev_ready)
);

// File: tb/tb_nand_strobe_gen.sv
module tb_nand_strobe_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [7:0]  req_data = 8'd0;
  logic [31:0] cfg_wr_timing = 32'd0;
  logic [31:0] cfg_rd_timing = 32'd0;
  logic        rb_n = 1'b1;
  logic [7:0]  pad_din = 8'd0;
  logic        pad_cle, pad_ale, pad_we_n, pad_re_n, pad_doe, done, busy, dev_ready;
  logic [7:0]  pad_dout, rd_data;

  int checks = 0;
  int failures = 0;
  int salt = 0;

  always #10 clk = ~clk;

  nand_strobe_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_data(req_data), .cfg_wr_timing(cfg_wr_timing), .cfg_rd_timing(cfg_rd_timing),
    .rb_n(rb_n), .pad_din(pad_din), .pad_cle(pad_cle), .pad_ale(pad_ale),
    .pad_we_n(pad_we_n), .pad_re_n(pad_re_n), .pad_dout(pad_dout), .pad_doe(pad_doe),
    .rd_data(rd_data), .done(done), .busy(busy), .dev_ready(dev_ready)
  );

  function automatic int ticks(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  function automatic int we_low(input logic [7:0] cyc, input logic [7:0] hi);
    return (cyc > hi) ? int'(cyc) - int'(hi) : 1;
  endfunction

  function automatic logic [7:0] din_at(input int n);
    return 8'((n * 37 + salt) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [7:0] b,
                           input logic [31:0] w1, input logic [31:0] w2,
                           input bit disturb, output int total_o);
    int s, lo, hi, ext, rlo, rhi, rrel, acc, kcap, exp_total, span;
    int n_we, n_re, n_cle, n_ale, n_doe, dout_bad, busy_bad, first_we, first_re, total;
    bit is_rd;
    is_rd = (k == 2'd3);
    s = ticks(w1[31:24]); ext = ticks(w1[23:16]);
    lo = we_low(w1[15:8], w1[7:0]); hi = ticks(w1[7:0]);
    acc = ticks(w2[31:24]); rhi = ticks(w2[23:16]);
    rlo = ticks(w2[15:8]); rrel = ticks(w2[7:0]);
    span = s + lo + hi;
    exp_total = is_rd ? (s + rlo + rhi + rrel) : (span + ext);
    kcap = (acc < rlo + rhi) ? acc : (rlo + rhi);
    salt = int'($urandom_range(0, 255));
    n_we = 0; n_re = 0; n_cle = 0; n_ale = 0; n_doe = 0; dout_bad = 0; busy_bad = 0;
    first_we = 0; first_re = 0; total = -1;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_data = b;
    cfg_wr_timing = w1; cfg_rd_timing = w2;
    @(posedge clk);
    for (int n = 1; n < 3000; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (disturb) begin
          cfg_wr_timing = $urandom; cfg_rd_timing = $urandom;
          req_kind = ~k; req_data = ~b;
        end else req_valid = 1'b0;
      end
      pad_din = din_at(n);
      if (done) begin
        req_valid = 1'b0;
        total = n - 1;
        break;
      end
      if (!busy) busy_bad++;
      if (!pad_we_n) begin n_we++; if (first_we == 0) first_we = n; end
      if (!pad_re_n) begin n_re++; if (first_re == 0) first_re = n; end
      if (pad_cle) n_cle++;
      if (pad_ale) n_ale++;
      if (pad_doe) begin n_doe++; if (pad_dout != b) dout_bad++; end
    end
    total_o = total;
    check(total == exp_total, is_rd ? "R8 total ticks" : "R7 total ticks", total, exp_total);
    check(busy_bad == 0, "R10 busy held", busy_bad, 0);
    check(n_we == (is_rd ? 0 : lo), "R4 we low ticks", n_we, is_rd ? 0 : lo);
    check(n_re == (is_rd ? rlo : 0), "R8 re low ticks", n_re, is_rd ? rlo : 0);
    check(n_doe == (is_rd ? 0 : span), "R6 doe ticks", n_doe, is_rd ? 0 : span);
    check(dout_bad == 0, "R6 dout value", dout_bad, 0);
    check(n_cle == ((k == 2'd0) ? span : 0), "R5 cle ticks", n_cle, (k == 2'd0) ? span : 0);
    check(n_ale == ((k == 2'd1) ? span : 0), "R5 ale ticks", n_ale, (k == 2'd1) ? span : 0);
    if (is_rd) begin
      check(first_re == s + 1, "R2 setup before re", first_re, s + 1);
      check(rd_data == din_at(s + kcap), "R9 captured byte", int'(rd_data), int'(din_at(s + kcap)));
    end else begin
      check(first_we == s + 1, "R2 setup before we", first_we, s + 1);
    end
    @(negedge clk);
    check(done == 1'b0, "R10 done one clock", int'(done), 0);
    check(busy == 1'b0, "R10 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pad_we_n && pad_re_n, "R1 strobes high", int'({pad_we_n, pad_re_n}), 3);
    check(!pad_cle && !pad_ale && !pad_doe, "R1 latches off", int'({pad_cle, pad_ale, pad_doe}), 0);
    check(!done && !busy, "R1 idle", int'({done, busy}), 0);

    // R3: all-zero fields give one tick per phase
    run_cycle(2'd0, 8'hA5, 32'd0, 32'd0, 1'b0, t);
    check(t == 4, "R3 zero write fields", t, 4);
    run_cycle(2'd3, 8'h00, 32'd0, 32'd0, 1'b0, t);
    check(t == 4, "R3 zero read fields", t, 4);
    // cycle shorter than high portion, long high portion
    run_cycle(2'd2, 8'h3C, {8'd2, 8'd3, 8'd5, 8'd9}, 32'd0, 1'b0, t);
    run_cycle(2'd1, 8'hC3, {8'd3, 8'd2, 8'd200, 8'd40}, 32'd0, 1'b0, t);
    // access beyond the strobe window, access inside the low phase
    run_cycle(2'd3, 8'h00, {8'd2, 8'd0, 8'd0, 8'd0}, {8'd30, 8'd3, 8'd4, 8'd2}, 1'b0, t);
    run_cycle(2'd3, 8'h00, 32'd0, {8'd2, 8'd3, 8'd6, 8'd1}, 1'b0, t);
    // R11: request held and inputs changed mid-cycle
    run_cycle(2'd0, 8'h5A, {8'd2, 8'd3, 8'd6, 8'd2}, {8'd1, 8'd1, 8'd1, 8'd1}, 1'b1, t);
    check(t == 2 + 4 + 2 + 3, "R11 snapshot timing", t, 11);
    run_cycle(2'd3, 8'h00, {8'd3, 8'd1, 8'd1, 8'd1}, {8'd3, 8'd2, 8'd4, 8'd5}, 1'b1, t);
    check(t == 3 + 4 + 2 + 5, "R11 snapshot read", t, 14);

    // R12: synchronizer latency
    @(negedge clk);
    rb_n = 1'b0;
    @(negedge clk);
    check(dev_ready == 1'b1, "R12 one edge later", int'(dev_ready), 1);
    @(negedge clk);
    check(dev_ready == 1'b0, "R12 two edges later", int'(dev_ready), 0);
    rb_n = 1'b1;

    for (int i = 0; i < 60; i++) begin
      logic [31:0] w1, w2;
      w1 = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 5)),
            8'($urandom_range(0, 9)), 8'($urandom_range(0, 5))};
      w2 = {8'($urandom_range(0, 12)), 8'($urandom_range(0, 5)),
            8'($urandom_range(0, 6)), 8'($urandom_range(0, 5))};
      run_cycle(2'($urandom_range(0, 3)), 8'($urandom), w1, w2,
                bit'($urandom_range(0, 3) == 0), t);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule